// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Decoder

This block is the control core of a single-data-rate synchronous burst SRAM. It samples three chip enables, a sleep input, two address strobes, an advance strobe and the write controls on every rising clock edge. From these it classifies the cycle as deselect, sleep, idle, begin-burst, continue-burst or suspend-burst. It then selects the address source for the cycle: the external address, the next burst address or the current one.

A small byte-laned array holds the data. Read data is registered. An asynchronous output enable gates it onto a data path, and that path is masked while a write is being presented. The array depth and the lane count are parameters.

The two address strobes behave differently. The processor-side strobe always starts a read, and a write may only follow it on a later continue or suspend cycle. The controller-side strobe may start a write in the same cycle.

Top module: `sync_burst_sram_ctrl`

## Requirements
- R1: The write term is active when `glob_wr_n` is low, or when `byte_wr_n` is low and at least one bit of `lane_wr_n` is low. Lane i covers `wdata[8i+7:8i]`. It is written for every lane when `glob_wr_n` is low, and otherwise only where `lane_wr_n[i]` is low.
- R2: Selection means `sel_a_n` low, `sel_b` high and `sel_c_n` low. With `proc_strobe_n` low, `sel_a_n` low, the device selected and sleep low, the cycle begins a read burst at `addr` and writes nothing, whatever the write controls are.
- R3: With `ctrl_strobe_n` low, the device selected, sleep low and R2 not applying, the cycle begins a burst at `addr`. It writes `wdata` at that same edge if the write term is active, and otherwise reads.
- R4: An address strobe that R2 or R3 would act on, presented while not selected, is a deselect: no access, and the burst ends. `proc_strobe_n` has no effect while `sel_a_n` is high.
- R5: With `sleep` high there is no access and the burst state is cleared. `rdata_drive` is low on the following cycle.
- R6: With no effective strobe and a burst active, `adv_n` low continues the burst. The low two address bits then step +1 with wrap from 3 to 0, and the upper bits are unchanged. `adv_n` high suspends the burst at the current address. Either cycle reads or writes according to the write term.
- R7: With no effective strobe and no burst active, the cycle is idle and makes no access.
- R8: The data of a read cycle appears on `rdata` for exactly the following clock cycle.
- R9: `out_en_n` is not sampled by the clock. While it is high, `rdata_drive` is low and `rdata` is zero, and the effect is immediate.
- R10: While the present inputs decode to a write access, `rdata_drive` is low.
- R11: After reset no burst is active and `rdata_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Chip enable A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip enable B, active high |
| sel_c_n | input | 1 | Chip enable C, active low |
| sleep | input | 1 | Sleep request, active high |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| glob_wr_n | input | 1 | Global write, all lanes, active low |
| byte_wr_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | External word address |
| wdata | input | LANES*LW | Write data |
| rdata | output | LANES*LW | Read data, zero when not driven |
| rdata_drive | output | 1 | High when the data path is driven |

## Verification
The hardest case to reach from the ports is a burst that wraps its low address bits and is then broken up. The break can be a suspend, a write on a continue cycle, a sleep or a deselect. A burst must first be opened with a strobe, and every later cycle must hold both strobes inactive for the burst to survive. Directed sequences open bursts near the wrap point and interleave advance, suspend and write cycles. A long weighted random phase then mixes strobes, enables and sleep, with the output enable toggled inside cycles. Each cycle is compared against a behavioural model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int BEAT_BITS = 2;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_DESEL,
        CYC_SLEEP,
        CYC_BEGIN,
        CYC_CONT,
        CYC_SUSP
    } cyc_kind_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_EXT,
        SRC_NEXT,
        SRC_CUR
    } addr_src_e;

    typedef struct packed {
        cyc_kind_e kind;
        addr_src_e src;
        logic      access;
        logic      is_write;
    } cyc_dec_t;

    function automatic logic [BEAT_BITS-1:0] beat_step(input logic [BEAT_BITS-1:0] b);
        return b + 1'b1;
    endfunction

endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             sleep,
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             adv_n,
    input  logic             glob_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             burst_on,
    output cyc_dec_t         dec,
    output logic [LANES-1:0] lane_mask
);

    logic selected;
    logic wr_term;

    assign selected = !sel_a_n && sel_b && !sel_c_n;
    assign wr_term  = !glob_wr_n || (!byte_wr_n && !(&lane_wr_n));

    always_comb begin
        if (!glob_wr_n)
            lane_mask = '1;
        else if (!byte_wr_n)
            lane_mask = ~lane_wr_n;
        else
            lane_mask = '0;
    end

    always_comb begin
        dec = '{kind: CYC_IDLE, src: SRC_NONE, access: 1'b0, is_write: 1'b0};
        if (sleep) begin
            dec.kind = CYC_SLEEP;
        end else if (!proc_strobe_n && !sel_a_n) begin
            if (selected) begin
                dec.kind   = CYC_BEGIN;
                dec.src    = SRC_EXT;
                dec.access = 1'b1;
            end else begin
                dec.kind = CYC_DESEL;
            end
        end else if (!ctrl_strobe_n) begin
            if (selected) begin
                dec.kind     = CYC_BEGIN;
                dec.src      = SRC_EXT;
                dec.access   = 1'b1;
                dec.is_write = wr_term;
            end else begin
                dec.kind = CYC_DESEL;
            end
        end else if (burst_on) begin
            dec.kind     = adv_n ? CYC_SUSP : CYC_CONT;
            dec.src      = adv_n ? SRC_CUR : SRC_NEXT;
            dec.access   = 1'b1;
            dec.is_write = wr_term;
        end
    end

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_dec_t      dec,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] cur_addr,
    output logic          burst_on
);

    logic [AW-1:0] next_addr;

    assign next_addr = {cur_addr[AW-1:BEAT_BITS], beat_step(cur_addr[BEAT_BITS-1:0])};

    always_comb begin
        case (dec.src)
            SRC_EXT:  eff_addr = ext_addr;
            SRC_NEXT: eff_addr = next_addr;
            default:  eff_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            burst_on <= 1'b0;
        end else begin
            case (dec.kind)
                CYC_SLEEP, CYC_DESEL: burst_on <= 1'b0;
                CYC_BEGIN: begin
                    cur_addr <= ext_addr;
                    burst_on <= 1'b1;
                end
                CYC_CONT: cur_addr <= next_addr;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [LANES-1:0]    lane_mask,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rword
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_mask[g])
                bank[addr] <= wdata[g*LW +: LW];
        end

        assign rword[g*LW +: LW] = bank[addr];
    end

endmodule

// File: rtl/sync_burst_sram_ctrl.sv
module sync_burst_sram_ctrl
    import sbs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                sleep,
    input  logic                proc_strobe_n,
    input  logic                ctrl_strobe_n,
    input  logic                adv_n,
    input  logic                glob_wr_n,
    input  logic                byte_wr_n,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic                out_en_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic                rdata_drive
);

    localparam int DW = LANES * LW;

    cyc_dec_t         dec;
    logic [LANES-1:0] lane_mask;
    logic             burst_on;
    logic [AW-1:0]    eff_addr;
    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    rword;
    logic [DW-1:0]    rdata_q;
    logic             rvalid_q;
    logic             wr_en;
    logic             rd_en;

    sbs_cycle_decode #(.LANES(LANES)) dec_i (
        .sel_a_n       (sel_a_n),
        .sel_b         (sel_b),
        .sel_c_n       (sel_c_n),
        .sleep         (sleep),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .glob_wr_n     (glob_wr_n),
        .byte_wr_n     (byte_wr_n),
        .lane_wr_n     (lane_wr_n),
        .burst_on      (burst_on),
        .dec           (dec),
        .lane_mask     (lane_mask)
    );

    sbs_burst_addr #(.AW(AW)) addr_i (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .ext_addr (addr),
        .eff_addr (eff_addr),
        .cur_addr (cur_addr),
        .burst_on (burst_on)
    );

    assign wr_en = dec.access && dec.is_write;
    assign rd_en = dec.access && !dec.is_write;

    sbs_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) mem_i (
        .clk       (clk),
        .we        (wr_en),
        .lane_mask (lane_mask),
        .addr      (eff_addr),
        .wdata     (wdata),
        .rword     (rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_en;
            if (rd_en)
                rdata_q <= rword;
        end
    end

    assign rdata_drive = !out_en_n && rvalid_q && !wr_en;
    assign rdata       = rdata_drive ? rdata_q : '0;

endmodule

// File: rtl/sbs_ctrl_chk.sv
module sbs_ctrl_chk #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          sleep,
    input logic          proc_strobe_n,
    input logic          ctrl_strobe_n,
    input logic          adv_n,
    input logic          out_en_n,
    input logic          rdata_drive,
    input logic          wr_en,
    input logic          burst_on,
    input logic [AW-1:0] cur_addr
);

    logic all_sel;
    logic ps_eff;
    logic no_strobe;

    assign all_sel   = !sel_a_n && sel_b && !sel_c_n;
    assign ps_eff    = !proc_strobe_n && !sel_a_n;
    assign no_strobe = !ps_eff && ctrl_strobe_n;

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_drive);

    // R10
    write_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rdata_drive);

    // R2
    proc_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ps_eff && !sleep) |-> !wr_en);

    // R5
    sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (!burst_on && !rdata_drive));

    // R4
    desel_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && (ps_eff || !ctrl_strobe_n) && !all_sel) |=> !burst_on);

    // R6
    advance_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && no_strobe && burst_on && !adv_n) |=>
        (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
        (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && no_strobe && burst_on && adv_n) |=> $stable(cur_addr));

    // R7
    idle_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && no_strobe && !burst_on) |-> !wr_en);

endmodule

bind sync_burst_sram_ctrl sbs_ctrl_chk #(.AW(AW), .LANES(LANES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sel_a_n       (sel_a_n),
    .sel_b         (sel_b),
    .sel_c_n       (sel_c_n),
    .sleep         (sleep),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .out_en_n      (out_en_n),
    .rdata_drive   (rdata_drive),
    .wr_en         (wr_en),
    .burst_on      (burst_on),
    .cur_addr      (cur_addr)
);

// File: tb/sync_burst_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_ctrl_tb_top;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 8;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, sleep = 1'b0;
    logic             proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, adv_n = 1'b1;
    logic             glob_wr_n = 1'b1, byte_wr_n = 1'b1, out_en_n = 1'b1;
    logic [LANES-1:0] lane_wr_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata;
    logic             rdata_drive;

    always #2 clk = ~clk;

    sync_burst_sram_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .sleep(sleep), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .glob_wr_n(glob_wr_n), .byte_wr_n(byte_wr_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_burst = 0;
    int            ref_addr = 0;
    bit            ref_rvalid = 0;
    logic [DW-1:0] ref_rdata = '0;

    // decoded kinds: 0 idle, 1 deselect, 2 sleep, 3 begin read-or-write, 4 continue, 5 suspend
    int   cur_kind;
    bit   cur_wr;
    int   cur_addr_used;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit wterm();
        return !glob_wr_n || (!byte_wr_n && lane_wr_n != '1);
    endfunction

    task automatic ref_decode();
        bit sel_ok;
        sel_ok = !sel_a_n && sel_b && !sel_c_n;
        cur_wr = 0;
        cur_addr_used = ref_addr;
        if (sleep) cur_kind = 2;
        else if (!proc_strobe_n && !sel_a_n) begin
            if (sel_ok) begin cur_kind = 3; cur_addr_used = int'(addr); end
            else cur_kind = 1;
        end else if (!ctrl_strobe_n) begin
            if (sel_ok) begin cur_kind = 3; cur_wr = wterm(); cur_addr_used = int'(addr); end
            else cur_kind = 1;
        end else if (ref_burst) begin
            if (!adv_n) begin
                cur_kind = 4;
                cur_addr_used = (ref_addr & ~3) | ((ref_addr + 1) & 3);
            end else cur_kind = 5;
            cur_wr = wterm();
        end else cur_kind = 0;
    endtask

    task automatic ref_update();
        bit acc;
        acc = (cur_kind >= 3);
        if (acc && cur_wr) begin
            for (int i = 0; i < LANES; i++)
                if (!glob_wr_n || (!byte_wr_n && !lane_wr_n[i]))
                    ref_mem[cur_addr_used][i*LW +: LW] = wdata[i*LW +: LW];
        end
        ref_rvalid = acc && !cur_wr;
        if (ref_rvalid) ref_rdata = ref_mem[cur_addr_used];
        if (cur_kind == 1 || cur_kind == 2) ref_burst = 0;
        if (cur_kind == 3) ref_burst = 1;
        if (cur_kind >= 3) ref_addr = cur_addr_used;
    endtask

    task automatic clear_inputs();
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; sleep = 1'b0;
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
        glob_wr_n = 1'b1; byte_wr_n = 1'b1; lane_wr_n = '1; out_en_n = 1'b0;
    endtask

    // inputs are already applied after a falling edge; compare, then step the model
    task automatic run_cycle(input string tag);
        bit exp_drv;
        #1;
        ref_decode();
        exp_drv = !out_en_n && ref_rvalid && !((cur_kind >= 3) && cur_wr);
        chk(tag, {{(DW-1){1'b0}}, rdata_drive}, {{(DW-1){1'b0}}, exp_drv});
        chk(tag, rdata, exp_drv ? ref_rdata : '0);
        if (!out_en_n) begin
            out_en_n = 1'b1;
            #0.4;
            // R9: release takes effect with no clock edge
            chk("R9", {{(DW-1){1'b0}}, rdata_drive}, '0);
            out_en_n = 1'b0;
            #0.2;
        end
        @(posedge clk);
        ref_update();
    endtask

    task automatic op_idle(input string tag);
        @(negedge clk); clear_inputs(); run_cycle(tag);
    endtask

    task automatic op_ps(input int a, input bit wr_ctl, input string tag);
        @(negedge clk); clear_inputs();
        proc_strobe_n = 1'b0; addr = AW'(a);
        if (wr_ctl) begin glob_wr_n = 1'b0; byte_wr_n = 1'b0; lane_wr_n = '0; wdata = 32'hBAD0_BAD0; end
        run_cycle(tag);
    endtask

    task automatic op_cs(input int a, input bit gw, input bit bw, input logic [LANES-1:0] ln,
                         input logic [DW-1:0] d, input string tag);
        @(negedge clk); clear_inputs();
        ctrl_strobe_n = 1'b0; addr = AW'(a);
        glob_wr_n = !gw; byte_wr_n = !bw; lane_wr_n = ln; wdata = d;
        run_cycle(tag);
    endtask

    task automatic op_adv(input bit go, input bit gw, input logic [DW-1:0] d, input string tag);
        @(negedge clk); clear_inputs();
        adv_n = !go; glob_wr_n = !gw; wdata = d;
        run_cycle(tag);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_inputs();
        // R11: nothing driven straight after reset
        run_cycle("R11");

        // R3: fill the array with controller-strobe global writes
        for (int a = 0; a < DEPTH; a++)
            op_cs(a, 1, 0, 4'hF, 32'hA5A5_0000 ^ (a * 32'h0101_0101), "R3");

        // R8: processor-strobe read, data one cycle later
        op_ps(5, 0, "R8");
        op_idle("R8");
        // R2: write controls ignored on the processor strobe
        op_ps(9, 1, "R2");
        op_idle("R2");
        op_ps(9, 0, "R2");
        op_idle("R2");

        // R1: partial-lane write, lanes 0 and 2 only
        op_cs(12, 0, 1, 4'b1010, 32'hDEAD_BEEF, "R1");
        op_ps(12, 0, "R1");
        op_idle("R1");
        // R1: lanes low but byte qualifier high gives a read
        op_cs(13, 0, 0, 4'b0000, 32'h1234_5678, "R1");
        op_idle("R1");

        // R6: burst from low bits 2, continue twice (wrap), suspend
        op_ps(6, 0, "R6");
        op_adv(1, 0, '0, "R6");
        op_adv(1, 0, '0, "R6");
        op_adv(0, 0, '0, "R6");
        op_adv(1, 1, 32'h0F0F_F0F0, "R6");
        op_ps(4, 0, "R6");
        op_adv(1, 0, '0, "R6");
        op_idle("R6");

        // R4: deselect ends the burst; R7 idle afterwards
        op_ps(20, 0, "R4");
        @(negedge clk); clear_inputs(); proc_strobe_n = 1'b0; sel_b = 1'b0; run_cycle("R4");
        op_adv(1, 1, 32'hFFFF_FFFF, "R7");
        op_ps(21, 0, "R4");
        @(negedge clk); clear_inputs(); proc_strobe_n = 1'b0; sel_a_n = 1'b1; adv_n = 1'b0; run_cycle("R4");
        op_idle("R4");

        // R5: sleep clears the burst
        op_ps(3, 0, "R5");
        @(negedge clk); clear_inputs(); sleep = 1'b1; ctrl_strobe_n = 1'b0; glob_wr_n = 1'b0; run_cycle("R5");
        op_adv(1, 1, 32'h7777_7777, "R5");
        op_ps(3, 0, "R5");
        op_idle("R5");

        // R9: output enable held inactive while read data is valid
        op_ps(10, 0, "R9");
        @(negedge clk); clear_inputs(); out_en_n = 1'b1; run_cycle("R9");

        // R10: write presented while read data is still valid
        op_ps(11, 0, "R10");
        op_cs(30, 1, 0, 4'hF, 32'hCAFE_0001, "R10");
        op_ps(11, 0, "R10");
        op_adv(0, 1, 32'hCAFE_0002, "R10");
        op_idle("R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            @(negedge clk); clear_inputs();
            r = int'($urandom % 16);
            addr = AW'($urandom);
            wdata = $urandom;
            if (r == 0) sleep = 1'b1;
            else if (r < 4) proc_strobe_n = 1'b0;
            else if (r < 8) ctrl_strobe_n = 1'b0;
            adv_n = $urandom % 2 == 0;
            if ($urandom % 8 == 0) sel_b = 1'b0;
            if ($urandom % 10 == 0) sel_a_n = 1'b1;
            if ($urandom % 12 == 0) sel_c_n = 1'b1;
            glob_wr_n = $urandom % 4 != 0;
            byte_wr_n = $urandom % 3 != 0;
            lane_wr_n = LANES'($urandom);
            out_en_n = $urandom % 5 == 0;
            run_cycle("R8");
        end

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule